// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block orders the entry into and the exit from a low-power state of a clock generator. The power-down request arrives asynchronously and is active low. It is synchronized first. The output clock groups are then parked low. The groups driven at the host rate stop on a falling edge of the internal CPU-rate clock. The reference group stops on a falling edge of its own slower clock, which can take several of its cycles. Only after every group is parked are the oscillator and VCO enables dropped.

When the request is released, the oscillator and VCO are enabled again. A settling counter then counts pulses of a free-running slow timebase up to a parameterized terminal count. After that, each group is released on a falling edge of its own source clock, so its first high pulse has full width. The state sequence is RUN, PARK, OFF and WAKE. A release that arrives while groups are still parking lets the park finish and then goes straight to WAKE, and the oscillator stays on throughout.

Clock levels are seen as data in the sequencer's clock domain. A falling edge is a sample high followed by a sample low. The analog PLL appears only as its enable.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset, osc_en and vco_en are 1 and every bit of grp_en is 0, and no group is enabled before the settling count completes.
- R2: pd_n passes through a two-stage synchronizer. No group enable falls within two clock cycles of pd_n going low.
- R3: A non-reference group enable (every index but NGRP-1) falls only on the clock edge at which cpu_clk is sampled low after being sampled high on the previous edge. All of them are 0 within 2 + 2*(cpu half period) + 2 cycles of pd_n going low.
- R4: The reference group enable (index NGRP-1) falls only on an edge at which grp_clk[NGRP-1] is sampled low after being sampled high on the previous edge.
- R5: osc_en falls only on an edge at which all of grp_en was already 0. While pd_n stays low after that, osc_en, vco_en and grp_en all stay 0.
- R6: On release from the off state, osc_en and vco_en rise together. No group enable rises until SETTLE pulses of tick have been counted.
- R7: After settling, grp_en[i] rises only on an edge at which grp_clk[i] is sampled low after being sampled high. All groups are enabled within (SETTLE+1) tick periods plus two of the slowest group's half periods plus 2 cycles of osc_en rising.
- R8: If pd_n returns high while groups are still parking, osc_en never falls, and all groups are enabled again after the settling count.
- R9: osc_en and vco_en are equal on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, faster than every clock it watches |
| rst_n | input | 1 | Active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_clk | input | 1 | Level of the internal CPU-rate clock |
| grp_clk | input | NGRP | Level of each group's source clock; index NGRP-1 is the reference group |
| tick | input | 1 | One-cycle pulse from the free-running slow timebase |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| grp_en | output | NGRP | Per-group output enables |

## Verification
The bench builds the block with four groups and SETTLE = 3. It uses a tick every 10 cycles, a CPU half period of 2 cycles and group half periods of 2, 3, 4 and 7 cycles. These small values keep every relative phase of the request, the CPU clock and the slow reference clock within a sweep of fourteen start offsets. The sweep covers both the case where the reference park ends early and the case where it ends late. The same setup also times a release that lands in the middle of a park, and it measures the settling bound within a few dozen cycles.

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
  parameter int NGRP   = 4,
  parameter int SETTLE = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_n,
  input  logic            cpu_clk,
  input  logic [NGRP-1:0] grp_clk,
  input  logic            tick,
  output logic            osc_en,
  output logic            vco_en,
  output logic [NGRP-1:0] grp_en
);
  localparam int REF = NGRP - 1;
  localparam int CW  = $clog2(SETTLE + 1);

  typedef enum logic [1:0] {RUN, PARK, OFF, WAKE} st_t;

  st_t             st;
  logic [1:0]      pd_sy;
  logic            cpu_q;
  logic [NGRP-1:0] grp_q;
  logic [CW-1:0]   cnt;
  logic [NGRP-1:0] stop, start;

  wire pd_act   = ~pd_sy[1];
  wire cpu_fall = cpu_q & ~cpu_clk;
  wire settled  = (cnt == CW'(SETTLE));

  assign start = grp_q & ~grp_clk;

  generate
    for (genvar i = 0; i < NGRP; i++) begin : g_stop
      if (i == REF) begin : g_ref
        assign stop[i] = start[i];
      end else begin : g_host
        assign stop[i] = cpu_fall;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_sy <= 2'b11;
      cpu_q <= 1'b0;
      grp_q <= '0;
    end else begin
      pd_sy <= {pd_sy[0], pd_n};
      cpu_q <= cpu_clk;
      grp_q <= grp_clk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= WAKE;
      osc_en <= 1'b1;
      vco_en <= 1'b1;
      grp_en <= '0;
      cnt    <= '0;
    end else begin
      case (st)
        RUN: if (pd_act) st <= PARK;
        PARK: begin
          grp_en <= grp_en & ~stop;
          if (grp_en == '0) begin
            cnt <= '0;
            if (pd_act) begin
              st     <= OFF;
              osc_en <= 1'b0;
              vco_en <= 1'b0;
            end else begin
              st <= WAKE;
            end
          end
        end
        OFF: if (!pd_act) begin
          st     <= WAKE;
          osc_en <= 1'b1;
          vco_en <= 1'b1;
          cnt    <= '0;
        end
        default: begin
          if (pd_act) begin
            st <= PARK;
          end else begin
            if (tick && !settled) cnt <= cnt + 1'b1;
            if (settled) grp_en <= grp_en | start;
            if (&grp_en) st <= RUN;
          end
        end
      endcase
    end
  end

  assert_osc_vco_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en == vco_en);

  assert_osc_off_after_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(grp_en) == '0);

  assert_off_outputs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> grp_en == '0);

  assert_release_powered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_en) != '0 |-> osc_en && settled);

  generate
    for (genvar i = 0; i < NGRP; i++) begin : g_chk
      if (i == REF) begin : g_ref_chk
        assert_ref_park_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
          $fell(grp_en[i]) |-> $past(grp_clk[i], 2) && !$past(grp_clk[i]));
      end else begin : g_host_chk
        assert_host_park_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
          $fell(grp_en[i]) |-> $past(cpu_clk, 2) && !$past(cpu_clk));
      end
      assert_clean_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_en[i]) |-> $past(grp_clk[i], 2) && !$past(grp_clk[i]));
    end
  endgenerate
endmodule

// File: tb/sim_pwrdn_seq.sv
module sim_pwrdn_seq;
  localparam int NG = 4;
  localparam int ST = 3;
  localparam int TP = 10;
  localparam int CH = 2;
  localparam int HMAX = 7;

  logic clk = 0, rst_n = 0, pd_n = 1, cpu_clk = 0, tick = 0;
  logic [NG-1:0] grp_clk = '0;
  logic osc_en, vco_en;
  logic [NG-1:0] grp_en;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  pwrdn_seq #(.NGRP(NG), .SETTLE(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cpu_clk(cpu_clk),
    .grp_clk(grp_clk), .tick(tick), .osc_en(osc_en), .vco_en(vco_en),
    .grp_en(grp_en));

  always #2.5 clk = ~clk;

  function automatic int half(int i);
    case (i)
      0: return 2;
      1: return 3;
      2: return 4;
      default: return HMAX;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    cpu_clk <= ((cyc / CH) % 2) == 1;
    tick <= (cyc % TP) == 0;
    for (int i = 0; i < NG; i++) grp_clk[i] <= ((cyc / half(i)) % 2) == 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic prev_cpu = 0, prev_osc = 1;
  logic [NG-1:0] prev_gc = '0, prev_en = '0;
  bit osc_dropped = 0;
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk(osc_en == vco_en, "R9", vco_en, osc_en);
      if (!osc_en && prev_osc) begin
        osc_dropped = 1;
        chk(prev_en == '0, "R5 order", prev_en, 0);
      end
      for (int i = 0; i < NG; i++) begin
        logic src_prev, src_now;
        src_prev = (i == NG-1) ? prev_gc[i] : prev_cpu;
        src_now  = (i == NG-1) ? grp_clk[i] : cpu_clk;
        if (prev_en[i] && !grp_en[i])
          chk(src_prev && !src_now, (i == NG-1) ? "R4 ref park edge" : "R3 park edge", {src_prev, src_now}, 2);
        if (!prev_en[i] && grp_en[i])
          chk(prev_gc[i] && !grp_clk[i], "R7 start edge", {prev_gc[i], grp_clk[i]}, 2);
      end
    end
    prev_cpu = cpu_clk;
    prev_gc  = grp_clk;
    prev_en  = grp_en;
    prev_osc = osc_en;
  end

  task automatic wait_wake_all(input string req);
    int n = 0, first = -1;
    while (grp_en != '1 && n < 400) begin
      @(posedge clk); #1; n++;
      if (first < 0 && grp_en != '0) first = n;
    end
    chk(first >= (ST - 1) * TP + 1, {req, " settle R6"}, first, (ST - 1) * TP + 1);
    chk(n <= (ST + 1) * TP + 2 * HMAX + 2, {req, " bound R7"}, n, (ST + 1) * TP + 2 * HMAX + 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(osc_en && vco_en, "R1 osc on", osc_en, 1);
    chk(grp_en == '0, "R1 groups off", grp_en, 0);
    @(negedge clk) rst_n = 1;
    wait_wake_all("R1");
    for (int off = 0; off < 2 * HMAX; off++) begin
      int n;
      repeat (off + 5) @(negedge clk);
      pd_n = 0;
      repeat (2) @(posedge clk);
      #1;
      chk(grp_en == '1, "R2 sync delay", grp_en, 15);
      n = 2;
      while (grp_en[NG-2:0] != '0 && n < 50) begin @(posedge clk); #1; n++; end
      chk(n <= 2 + 2 * CH + 2, "R3 park latency", n, 2 + 2 * CH + 2);
      while (osc_en && n < 60) begin @(posedge clk); #1; n++; end
      chk(!osc_en && grp_en == '0, "R5 off reached", osc_en, 0);
      repeat (30) @(posedge clk);
      #1;
      chk(!osc_en && !vco_en && grp_en == '0, "R5 hold off", grp_en, 0);
      @(negedge clk) pd_n = 1;
      n = 0;
      while (!osc_en && n < 10) begin @(posedge clk); #1; n++; end
      chk(osc_en && vco_en && n <= 4, "R6 power on", n, 3);
      wait_wake_all("R7");
    end
    for (int off = 0; off < 4; off++) begin
      repeat (off + 3) @(negedge clk);
      osc_dropped = 0;
      pd_n = 0;
      while (grp_en[0]) @(negedge clk);
      pd_n = 1;
      repeat (5) @(posedge clk);
      #1;
      wait_wake_all("R8");
      chk(!osc_dropped, "R8 osc kept", osc_dropped, 0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule